// File: doc/BRIEF.md
# Double-Buffered Output Gamma Lookup

This block applies a piecewise-linear transfer curve to a stream of three-component pixels. It owns two complete curve stores, A and B, each holding a base value and a per-segment slope for every curve point of all three components. One store drives the pixel path while the host fills the other, so a new curve can be staged at any time without disturbing the visible picture.

The host loads a curve through one data port that fills itself in order. Each point takes six consecutive words, and a three-bit mask chooses which components actually store their words. A write aimed at the store currently in use is refused and raises a sticky flag. A requested mode (bypass, A or B) only takes effect on a frame-start pulse, so the active curve never changes partway through a frame. A power-enable input must be high for loading and lookup. While it is low, words are ignored and pixels pass through unchanged.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: After synchronous reset, `cfg_status` is 0 (bypass), `wr_err` is 0 and `out_valid` is 0.
- R2: A `mode_wr` pulse stores `mode_val` as the pending mode, with 0 = bypass, 1 = store A and 2 = store B, and 3 stored as bypass. `cfg_status` takes the pending value only on a cycle with `frame_start` high and otherwise holds. It only ever reads 0, 1 or 2.
- R3: In bypass mode each output component equals its input component.
- R4: After an `idx_clr` pulse, accepted data words fill the curve in this order: red base, green base, blue base, red slope, green slope, blue slope. The point index then advances by one after each sixth accepted word.
- R5: Outside bypass, the upper PT_W bits of a component choose the point, and the lower PIX_W-PT_W bits form the fraction f. The output is base + floor(slope*f / 2^(PIX_W-PT_W)), saturated to 2^PIX_W-1.
- R6: Mask bit 0 enables red, bit 1 green and bit 2 blue. A word for a masked-off component still takes its place in the sequence but is not stored.
- R7: `wr_ram_sel` 0 targets store A and 1 targets store B. A word aimed at the store named by `cfg_status` is not stored, does not advance the sequence, and sets `wr_err`. `wr_err` stays set until reset.
- R8: Words that arrive after all 2^PT_W points have been filled are dropped and change no stored point.
- R9: While `lut_pwr_en` is low, data words are ignored and do not set `wr_err`, and pixels come out unchanged.
- R10: A pixel that arrives in the same cycle as `frame_start` is processed with the newly latched mode.
- R11: `out_valid` rises exactly two cycles after `pix_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_pwr_en | input | 1 | Keeps the curve stores powered; low means bypass and no loading |
| wr_ram_sel | input | 1 | Target store for loading: 0 = A, 1 = B |
| wr_chan_mask | input | 3 | Component write mask (bit 0 red, bit 1 green, bit 2 blue) |
| idx_clr | input | 1 | Returns the load position to point 0, word 0 |
| wr_valid | input | 1 | Data word present |
| wr_data | input | PIX_W | Data word (base or slope) |
| mode_wr | input | 1 | Stores mode_val as the pending mode |
| mode_val | input | 2 | Requested mode: 0 bypass, 1 A, 2 B |
| frame_start | input | 1 | Frame boundary; latches the pending mode |
| pix_valid | input | 1 | Input pixel present |
| pix_in | input | 3 x PIX_W | Input components, index 0 red, 1 green, 2 blue |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 3 x PIX_W | Corrected components, same order as pix_in |
| cfg_status | output | 2 | Active mode: 0 bypass, 1 A, 2 B |
| wr_err | output | 1 | Sticky flag for a write refused because it aimed at the active store |

## Verification
A frame-start pulse and a pixel can arrive in the same clock, and the mode switch then has to govern that very pixel. The bench stages a new curve with a mode write, then sends one pixel without a frame start and expects it to follow the old mode. It then sends the next pixel together with the frame start and expects that pixel to follow the new curve. The scoreboard judges both through the output values and through `cfg_status`, which must hold until the pulse and change at it.

// File: rtl/glut_pkg.sv
package glut_pkg;
  localparam logic [1:0] GM_BYPASS = 2'd0;
  localparam logic [1:0] GM_RAM_A  = 2'd1;
  localparam logic [1:0] GM_RAM_B  = 2'd2;

  // the unused code folds to bypass (R2)
  function automatic logic [1:0] gm_norm(input logic [1:0] m);
    return (m == 2'd3) ? GM_BYPASS : m;
  endfunction
endpackage

// File: rtl/glut_bank.sv
// One curve store for one component: base and slope memories with a
// registered read, written one word at a time.
module glut_bank #(
  parameter int PT_W  = 4,
  parameter int VAL_W = 10
) (
  input  logic             clk,
  input  logic             we_base,
  input  logic             we_dlt,
  input  logic [PT_W-1:0]  waddr,
  input  logic [VAL_W-1:0] wdata,
  input  logic [PT_W-1:0]  raddr,
  output logic [VAL_W-1:0] rbase,
  output logic [VAL_W-1:0] rdlt
);
  localparam int DEPTH = 1 << PT_W;

  logic [VAL_W-1:0] base_mem [DEPTH];
  logic [VAL_W-1:0] dlt_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (we_base) base_mem[waddr] <= wdata;
    rbase <= base_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we_dlt) dlt_mem[waddr] <= wdata;
    rdlt <= dlt_mem[raddr];
  end
endmodule

// File: rtl/glut_loader.sv
// Sequences host words into the idle store and flags writes at the busy one.
module glut_loader #(
  parameter int PT_W = 4,
  parameter int NPTS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_en,
  input  logic            wr_valid,
  input  logic            ram_sel,
  input  logic [2:0]      chan_mask,
  input  logic            idx_clr,
  input  logic [1:0]      active_mode,
  output logic [5:0]      we_base,
  output logic [5:0]      we_dlt,
  output logic [PT_W-1:0] waddr,
  output logic            err
);
  import glut_pkg::*;

  logic [2:0]    phase;
  logic [PT_W:0] idx;
  logic          attempt, hit, room, accept, is_dlt;
  logic [1:0]    chan;

  assign attempt = wr_valid && pwr_en && !idx_clr;
  assign hit     = (active_mode == GM_RAM_A && !ram_sel) ||
                   (active_mode == GM_RAM_B &&  ram_sel);
  assign room    = idx < (PT_W+1)'(NPTS);
  assign accept  = attempt && !hit && room;
  assign is_dlt  = phase >= 3'd3;
  assign chan    = is_dlt ? 2'(phase - 3'd3) : phase[1:0];
  assign waddr   = idx[PT_W-1:0];

  always_comb begin
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 3; c++) begin
        we_base[r*3+c] = accept && (ram_sel == r[0]) && !is_dlt &&
                         (chan == c[1:0]) && chan_mask[c];
        we_dlt[r*3+c]  = accept && (ram_sel == r[0]) &&  is_dlt &&
                         (chan == c[1:0]) && chan_mask[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      idx   <= '0;
      err   <= 1'b0;
    end else begin
      if (idx_clr) begin
        phase <= '0;
        idx   <= '0;
      end else if (accept) begin
        if (phase == 3'd5) begin
          phase <= '0;
          idx   <= idx + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
      if (attempt && hit) err <= 1'b1;
    end
  end
endmodule

// File: rtl/glut_interp.sv
// One component: base plus scaled slope, saturated, or pass-through.
module glut_interp #(
  parameter int PIX_W = 10,
  parameter int PT_W  = 4
) (
  input  logic             clk,
  input  logic             byp,
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] base,
  input  logic [PIX_W-1:0] dlt,
  output logic [PIX_W-1:0] q
);
  localparam int FR_W = PIX_W - PT_W;

  logic [PIX_W+FR_W-1:0] prod;
  logic [PIX_W-1:0]      inc;
  logic [PIX_W:0]        sum;

  assign prod = {{FR_W{1'b0}}, dlt} * {{PIX_W{1'b0}}, pix[FR_W-1:0]};
  assign inc  = prod[PIX_W+FR_W-1:FR_W];
  assign sum  = {1'b0, base} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (byp)               q <= pix;
    else if (sum[PIX_W])   q <= '1;
    else                   q <= sum[PIX_W-1:0];
  end
endmodule

// File: rtl/gamma_pingpong_lut.sv
module gamma_pingpong_lut #(
  parameter int PIX_W = 10,
  parameter int PT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lut_pwr_en,
  input  logic                  wr_ram_sel,
  input  logic [2:0]            wr_chan_mask,
  input  logic                  idx_clr,
  input  logic                  wr_valid,
  input  logic [PIX_W-1:0]      wr_data,
  input  logic                  mode_wr,
  input  logic [1:0]            mode_val,
  input  logic                  frame_start,
  input  logic                  pix_valid,
  input  logic [2:0][PIX_W-1:0] pix_in,
  output logic                  out_valid,
  output logic [2:0][PIX_W-1:0] out_pix,
  output logic [1:0]            cfg_status,
  output logic                  wr_err
);
  import glut_pkg::*;

  localparam int FR_W = PIX_W - PT_W;
  localparam int NPTS = 1 << PT_W;

  logic [1:0] active_q, pend_q, mode_next;
  logic       v0, byp0, bsel0;
  logic [2:0][PIX_W-1:0] pix0;
  logic [5:0] we_base, we_dlt;
  logic [PT_W-1:0] waddr;
  logic [PIX_W-1:0] rbase [2][3];
  logic [PIX_W-1:0] rdlt  [2][3];

  // pending mode takes over on the frame-start cycle itself (R10)
  assign mode_next = frame_start ? pend_q : active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= GM_BYPASS;
      pend_q   <= GM_BYPASS;
    end else begin
      if (mode_wr)     pend_q   <= gm_norm(mode_val);
      if (frame_start) active_q <= pend_q;
    end
  end

  assign cfg_status = active_q;

  glut_loader #(.PT_W(PT_W), .NPTS(NPTS)) loader_i (
    .clk(clk), .rst(rst), .pwr_en(lut_pwr_en), .wr_valid(wr_valid),
    .ram_sel(wr_ram_sel), .chan_mask(wr_chan_mask), .idx_clr(idx_clr),
    .active_mode(active_q), .we_base(we_base), .we_dlt(we_dlt),
    .waddr(waddr), .err(wr_err)
  );

  for (genvar r = 0; r < 2; r++) begin : g_ram
    for (genvar c = 0; c < 3; c++) begin : g_chan
      glut_bank #(.PT_W(PT_W), .VAL_W(PIX_W)) bank_i (
        .clk(clk), .we_base(we_base[r*3+c]), .we_dlt(we_dlt[r*3+c]),
        .waddr(waddr), .wdata(wr_data),
        .raddr(pix_in[c][PIX_W-1:FR_W]),
        .rbase(rbase[r][c]), .rdlt(rdlt[r][c])
      );
    end
  end

  // stage 0: store read is in flight, control rides alongside
  always_ff @(posedge clk) begin
    if (rst) v0 <= 1'b0;
    else     v0 <= pix_valid;
    pix0  <= pix_in;
    byp0  <= !lut_pwr_en || (mode_next == GM_BYPASS);
    bsel0 <= (mode_next == GM_RAM_B);
  end

  // stage 1: arithmetic and output register
  for (genvar c = 0; c < 3; c++) begin : g_out
    logic [PIX_W-1:0] sel_base, sel_dlt;
    assign sel_base = bsel0 ? rbase[1][c] : rbase[0][c];
    assign sel_dlt  = bsel0 ? rdlt[1][c]  : rdlt[0][c];
    glut_interp #(.PIX_W(PIX_W), .PT_W(PT_W)) interp_i (
      .clk(clk), .byp(byp0), .pix(pix0[c]),
      .base(sel_base), .dlt(sel_dlt), .q(out_pix[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v0;
  end
endmodule

// File: rtl/glut_chk.sv
module glut_chk #(
  parameter int PIX_W = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lut_pwr_en,
  input logic                  wr_ram_sel,
  input logic                  idx_clr,
  input logic                  wr_valid,
  input logic                  frame_start,
  input logic                  pix_valid,
  input logic [2:0][PIX_W-1:0] pix_in,
  input logic                  out_valid,
  input logic [2:0][PIX_W-1:0] out_pix,
  input logic [1:0]            cfg_status,
  input logic                  wr_err
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cfg_status == 2'd0 && !wr_err && !out_valid));

  // R2
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_status != 2'd3);

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(cfg_status));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  // R7
  reject_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && lut_pwr_en && !idx_clr &&
     ((cfg_status == 2'd1 && !wr_ram_sel) || (cfg_status == 2'd2 && wr_ram_sel)))
    |=> wr_err);

  // R9
  pwr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!lut_pwr_en && !wr_err) |=> !wr_err);

  // R9
  pwr_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !lut_pwr_en) |-> ##2 (out_pix == $past(pix_in, 2)));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ##2 out_valid);
endmodule

bind gamma_pingpong_lut glut_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst(rst), .lut_pwr_en(lut_pwr_en), .wr_ram_sel(wr_ram_sel),
  .idx_clr(idx_clr), .wr_valid(wr_valid), .frame_start(frame_start),
  .pix_valid(pix_valid), .pix_in(pix_in), .out_valid(out_valid),
  .out_pix(out_pix), .cfg_status(cfg_status), .wr_err(wr_err)
);

// File: tb/gamma_pingpong_lut_tb_top.sv
module gamma_pingpong_lut_tb_top;
  localparam int PIX_W = 10;
  localparam int PT_W  = 4;
  localparam int FR_W  = PIX_W - PT_W;
  localparam int NPTS  = 1 << PT_W;
  localparam int MAXV  = (1 << PIX_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lut_pwr_en = 1'b0, wr_ram_sel = 1'b0, idx_clr = 1'b0, wr_valid = 1'b0;
  logic [2:0] wr_chan_mask = 3'b111;
  logic [PIX_W-1:0] wr_data = '0;
  logic mode_wr = 1'b0, frame_start = 1'b0, pix_valid = 1'b0;
  logic [1:0] mode_val = '0;
  logic [2:0][PIX_W-1:0] pix_in = '0;
  logic out_valid, wr_err;
  logic [2:0][PIX_W-1:0] out_pix;
  logic [1:0] cfg_status;

  always #10 clk = ~clk;

  gamma_pingpong_lut #(.PIX_W(PIX_W), .PT_W(PT_W)) dut_i (
    .clk(clk), .rst(rst), .lut_pwr_en(lut_pwr_en), .wr_ram_sel(wr_ram_sel),
    .wr_chan_mask(wr_chan_mask), .idx_clr(idx_clr), .wr_valid(wr_valid),
    .wr_data(wr_data), .mode_wr(mode_wr), .mode_val(mode_val),
    .frame_start(frame_start), .pix_valid(pix_valid), .pix_in(pix_in),
    .out_valid(out_valid), .out_pix(out_pix), .cfg_status(cfg_status),
    .wr_err(wr_err)
  );

  int checks = 0;
  int errors = 0;

  // model state, built from the requirements
  int m_base [2][3][NPTS];
  int m_dlt  [2][3][NPTS];
  int m_phase = 0, m_idx = 0, m_active = 0, m_pend = 0;
  bit m_pwr = 1'b0;
  string cur_tag = "R3";

  typedef struct { int v[3]; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_val(int c, int p);
    int ram, idx, fr, v;
    if (!m_pwr || m_active == 0) return p;
    ram = m_active - 1;
    idx = p >> FR_W;
    fr  = p & ((1 << FR_W) - 1);
    v   = m_base[ram][c][idx] + ((m_dlt[ram][c][idx] * fr) >> FR_W);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic defaults();
    wr_valid = 1'b0; idx_clr = 1'b0; mode_wr = 1'b0;
    frame_start = 1'b0; pix_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      defaults();
    end
  endtask

  task automatic set_pwr(bit b);
    @(negedge clk); defaults();
    lut_pwr_en = b; m_pwr = b;
  endtask

  task automatic clr_idx();
    @(negedge clk); defaults();
    idx_clr = 1'b1; m_phase = 0; m_idx = 0;
  endtask

  task automatic set_mode(int m);
    @(negedge clk); defaults();
    mode_wr = 1'b1; mode_val = 2'(m);
    m_pend = (m == 3) ? 0 : m;
  endtask

  task automatic send_word(bit sel, int data);
    int ch;
    bit hit;
    @(negedge clk); defaults();
    wr_valid = 1'b1; wr_ram_sel = sel; wr_data = PIX_W'(data);
    if (m_pwr) begin
      hit = (m_active == 1 && !sel) || (m_active == 2 && sel);
      if (!hit && m_idx < NPTS) begin
        ch = m_phase % 3;
        if (wr_chan_mask[ch]) begin
          if (m_phase < 3) m_base[sel][ch][m_idx] = data;
          else             m_dlt[sel][ch][m_idx]  = data;
        end
        if (m_phase == 5) begin m_phase = 0; m_idx++; end
        else m_phase++;
      end
    end
  endtask

  // driver: present one pixel and queue what the scoreboard must see
  task automatic send_pix(int r, int g, int b, bit fs);
    exp_t e;
    @(negedge clk); defaults();
    pix_valid = 1'b1; frame_start = fs;
    pix_in[0] = PIX_W'(r); pix_in[1] = PIX_W'(g); pix_in[2] = PIX_W'(b);
    if (fs) m_active = m_pend;
    e.v[0] = exp_val(0, r); e.v[1] = exp_val(1, g); e.v[2] = exp_val(2, b);
    e.tag = cur_tag;
    exp_q.push_back(e);
  endtask

  function automatic int curve(int k, int i, int w);
    int c;
    c = w % 3;
    case (k)
      0: return (w < 3) ? i*60 + c*3 : ((i == NPTS-1) ? 1000 : 20 + i*3 + c);
      1: return (w < 3) ? 1000 - i*50 - c : 10 + i + c*2;
      default: return (w < 3) ? 500 + c : 1 + c;
    endcase
  endfunction

  task automatic load_pts(bit sel, int k, int lo, int hi);
    for (int i = lo; i <= hi; i++)
      for (int w = 0; w < 6; w++)
        send_word(sel, curve(k, i, w));
  endtask

  task automatic sweep();
    send_pix(0*64 + 33, 0*64 + 10, 0*64 + 63, 1'b0);
    send_pix(1*64 + 5,  1*64 + 40, 1*64 + 0,  1'b0);
    send_pix(5*64 + 33, 7*64 + 0,  9*64 + 17, 1'b0);
    send_pix(15*64 + 63, 15*64 + 1, 14*64 + 50, 1'b0);
  endtask

  // monitor: scoreboard comparison as results leave the design
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected output", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        for (int c = 0; c < 3; c++) chk(e.tag, int'(out_pix[c]), e.v[c]);
      end
    end
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(cfg_status), 0);
    chk("R1 err", int'(wr_err), 0);
    chk("R1 valid", int'(out_valid), 0);

    set_pwr(1'b1);
    // R3 bypass under several patterns
    cur_tag = "R3";
    send_pix(0, 512, 1023, 1'b0);
    send_pix(77, 300, 999, 1'b0);
    idle(4);

    // R11 single pixel latency
    cur_tag = "R11";
    send_pix(100, 200, 300, 1'b0);
    @(negedge clk); defaults();
    chk("R11 one cycle", int'(out_valid), 0);
    @(negedge clk);
    chk("R11 two cycles", int'(out_valid), 1);
    idle(3);

    // R4 load full curve into store B
    clr_idx();
    load_pts(1'b1, 0, 0, NPTS-1);
    idle(1);

    // R2/R10: pending mode waits for frame start
    set_mode(2);
    idle(1);
    chk("R2 status before frame", int'(cfg_status), 0);
    cur_tag = "R10";
    send_pix(5*64 + 33, 5*64 + 33, 5*64 + 33, 1'b0);
    send_pix(5*64 + 33, 5*64 + 33, 5*64 + 33, 1'b1);
    idle(1);
    chk("R2 status after frame", int'(cfg_status), 2);
    cur_tag = "R5";
    sweep();
    idle(4);

    // R9 power off: bypass and dropped words
    clr_idx();
    set_pwr(1'b0);
    cur_tag = "R9";
    send_pix(15*64 + 63, 321, 5, 1'b0);
    for (int w = 0; w < 6; w++) send_word(1'b0, 777);
    idle(3);
    chk("R9 no err", int'(wr_err), 0);
    set_pwr(1'b1);

    // R4/R7 load store A with a refused word in between
    load_pts(1'b0, 1, 0, 4);
    send_word(1'b1, 123);
    idle(1);
    chk("R7 err set", int'(wr_err), 1);
    load_pts(1'b0, 1, 5, NPTS-1);
    // R8 extra words beyond the last point
    for (int w = 0; w < 6; w++) send_word(1'b0, 99);
    // R6 masked reload, green keeps its old words
    clr_idx();
    wr_chan_mask = 3'b101;
    load_pts(1'b0, 2, 0, 1);
    idle(1);
    wr_chan_mask = 3'b111;
    chk("R7 err sticky", int'(wr_err), 1);

    // R7 store B still holds its curve
    cur_tag = "R7";
    sweep();
    idle(4);

    set_mode(1);
    cur_tag = "R6";
    send_pix(0*64 + 40, 0*64 + 40, 1*64 + 20, 1'b1);
    idle(1);
    chk("R2 status A", int'(cfg_status), 1);
    cur_tag = "R8";
    send_pix(0*64 + 0, 0*64 + 63, 0*64 + 7, 1'b0);
    cur_tag = "R4";
    sweep();
    idle(4);

    // R2 unused code reads as bypass
    set_mode(3);
    cur_tag = "R2";
    send_pix(12, 600, 1000, 1'b1);
    idle(1);
    chk("R2 code three", int'(cfg_status), 0);
    idle(4);

    chk("R11 queue drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule